// File: doc/BRIEF.md
# Phase-Offset Integer Clock Divider

This block divides a fast input clock by a programmable integer and produces two divided clocks: a reference output with no offset and an adjusted output whose phase is moved in whole input-clock periods. The phase is not set by changing any output period. Instead, a delay counter keeps the adjusted divider idle after the sync event, which is the release of the active-low reset. Once the programmed number of input edges has passed, the adjusted divider starts. With divide by N there are N distinct phase positions, each one input period apart, or 360/N degrees of the output period. For example, an offset of 4 at divide by 16 moves the output by a quarter of its period, and each step at divide by 32 is 11.25 degrees.

The divide ratio and the offset are sampled while reset is held low. After release they are frozen, so new settings take effect only at the next sync. Each output lane is a three-state machine. ST_WAIT counts delay edges and goes to ST_HIGH when the count reaches the lane's offset. ST_HIGH goes to ST_LOW after the high length, or stays in ST_HIGH when the low length is zero. ST_LOW returns to ST_HIGH after the low length. Reset forces ST_WAIT. At divide by 1, both outputs pass the input clock straight through.

Top module: `clk_phase_div`

## Requirements
- R1: While rst_n is low, clk_ref and clk_adj are both low.
- R2: div_ratio and phase_off are sampled only while rst_n is low. Changes made while rst_n is high do not affect the outputs until the next reset.
- R3: For N ≥ 2, clk_ref goes high at the first rising clk_in edge after rst_n rises. It repeats every N input cycles, is high for (N+1)/2 cycles (integer division) and is low for the rest.
- R4: clk_adj stays low after release until its first rise, which comes exactly P input cycles after the first rise of clk_ref. P is the effective offset.
- R5: Once running, clk_adj has the same period and high time as clk_ref. Each output value matches clk_ref delayed by P cycles, with no stretched cycle.
- R6: The effective offset P is phase_off modulo N. In particular, P = 0 makes clk_adj identical to clk_ref.
- R7: The effective ratio N is the value of div_ratio, except that 0 is treated as 1 and any value above 80 is treated as 80.
- R8: With N = 1 and rst_n high, clk_ref and clk_adj both equal clk_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low reset; its release is the sync start |
| div_ratio | input | 7 | Requested divide ratio |
| phase_off | input | 7 | Requested phase offset in input cycles |
| clk_ref | output | 1 | Divided clock with no offset |
| clk_adj | output | 1 | Divided clock delayed by the effective offset |

## Verification
The bench builds the block with its default parameters: a 7-bit ratio and offset and a maximum ratio of 80. This covers the full ratio range, the clamping of 0 and of values above 80, and offsets that wrap modulo N. Every sync is followed for the whole delay window plus two output periods, so both the first-edge timing and the steady-state duty cycle are checked for odd ratios, even ratios and the pass-through ratio of 1.

// File: rtl/clk_phase_div_pkg.sv
package clk_phase_div_pkg;
    parameter int unsigned VAL_W     = 7;
    parameter int unsigned MAX_RATIO = 80;
    localparam int unsigned LANES    = 2;

    typedef logic [VAL_W-1:0] val_t;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } lane_state_e;

    typedef struct packed {
        val_t ratio;
        val_t offset;
        val_t hi_len;
        val_t lo_len;
    } div_cfg_t;
endpackage

// File: rtl/cpd_cfg_capture.sv
module cpd_cfg_capture
    import clk_phase_div_pkg::*;
#(
    parameter int unsigned W     = VAL_W,
    parameter int unsigned R_MAX = MAX_RATIO
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio_in,
    input  logic [W-1:0] offset_in,
    output div_cfg_t     cfg
);
    localparam logic [W-1:0] RMAX_V = W'(R_MAX);
    localparam logic [W-1:0] ONE_V  = W'(1);

    logic [W-1:0] ratio_c;
    logic [W-1:0] offset_c;
    logic [W-1:0] hi_c;
    div_cfg_t     cfg_q;

    always_comb begin
        if (ratio_in == '0) begin
            ratio_c = ONE_V;
        end else if (ratio_in > RMAX_V) begin
            ratio_c = RMAX_V;
        end else begin
            ratio_c = ratio_in;
        end
        offset_c = offset_in % ratio_c;
        hi_c     = W'((ratio_c + ONE_V) >> 1);
    end

    // capture only while sync/reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.ratio  <= ratio_c;
            cfg_q.offset <= offset_c;
            cfg_q.hi_len <= hi_c;
            cfg_q.lo_len <= ratio_c - hi_c;
        end
    end

    assign cfg = cfg_q;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(cfg_q)) else $error("cfg changed while running"); // R2
endmodule

// File: rtl/cpd_lane.sv
module cpd_lane
    import clk_phase_div_pkg::*;
#(
    parameter int unsigned W = VAL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] offset,
    input  logic [W-1:0] hi_len,
    input  logic [W-1:0] lo_len,
    output logic         div_out
);
    localparam logic [W-1:0] ONE_V = W'(1);

    lane_state_e  state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         out_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + ONE_V;
        unique case (state_q)
            ST_WAIT: begin
                if (cnt_q == offset) begin
                    state_d = ST_HIGH;
                    cnt_d   = ONE_V;
                end
            end
            ST_HIGH: begin
                if (cnt_q == hi_len) begin
                    state_d = (lo_len == '0) ? ST_HIGH : ST_LOW;
                    cnt_d   = ONE_V;
                end
            end
            ST_LOW: begin
                if (cnt_q == lo_len) begin
                    state_d = ST_HIGH;
                    cnt_d   = ONE_V;
                end
            end
            default: begin
                state_d = ST_WAIT;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            out_q <= (state_d == ST_HIGH);
        end
    end

    assign div_out = out_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_LANE_RESET_LOW: assert (!out_q) else $error("lane high in reset"); // R1
        end
    end

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (cnt_q <= offset && !out_q)) else $error("wait overrun"); // R4
    AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH) |-> (cnt_q <= hi_len && out_q)) else $error("high overrun"); // R3
    AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW) |-> (cnt_q <= lo_len && !out_q)) else $error("low overrun"); // R3
endmodule

// File: rtl/clk_phase_div.sv
module clk_phase_div
    import clk_phase_div_pkg::*;
#(
    parameter int unsigned W     = VAL_W,
    parameter int unsigned R_MAX = MAX_RATIO
) (
    input  logic         clk_in,
    input  logic         rst_n,
    input  logic [W-1:0] div_ratio,
    input  logic [W-1:0] phase_off,
    output logic         clk_ref,
    output logic         clk_adj
);
    localparam logic [W-1:0] ONE_V = W'(1);

    div_cfg_t         cfg;
    logic [LANES-1:0] lane_out;
    logic             bypass;

    cpd_cfg_capture #(.W(W), .R_MAX(R_MAX)) u_cfg (
        .clk       (clk_in),
        .rst_n     (rst_n),
        .ratio_in  (div_ratio),
        .offset_in (phase_off),
        .cfg       (cfg)
    );

    // lane 0 is the unshifted reference, lane 1 the adjusted one
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cpd_lane #(.W(W)) u_lane (
            .clk     (clk_in),
            .rst_n   (rst_n),
            .offset  ((g == 0) ? '0 : cfg.offset),
            .hi_len  (cfg.hi_len),
            .lo_len  (cfg.lo_len),
            .div_out (lane_out[g])
        );
    end

    assign bypass  = rst_n && (cfg.ratio == ONE_V);
    assign clk_ref = bypass ? clk_in : lane_out[0];
    assign clk_adj = bypass ? clk_in : lane_out[1];

    AST_ZERO_OFF_MATCH: assert property (@(posedge clk_in) disable iff (!rst_n)
        (cfg.offset == '0) |-> (lane_out[1] == lane_out[0])) else $error("offset 0 mismatch"); // R6
    AST_RATIO_RANGE: assert property (@(posedge clk_in) disable iff (!rst_n)
        1'b1 |-> (cfg.ratio >= ONE_V && cfg.ratio <= W'(R_MAX))) else $error("ratio out of range"); // R7
endmodule

// File: tb/test_clk_phase_div.sv
`timescale 1ns/1ps
module test_clk_phase_div;
    logic       clk_in = 1'b0;
    logic       rst_n  = 1'b0;
    logic [6:0] div_ratio = 7'd4;
    logic [6:0] phase_off = 7'd0;
    logic       clk_ref, clk_adj;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk_in = ~clk_in;

    clk_phase_div i_clk_phase_div (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .div_ratio (div_ratio),
        .phase_off (phase_off),
        .clk_ref   (clk_ref),
        .clk_adj   (clk_adj)
    );

    function automatic int eff_ratio(int r);
        if (r == 0) return 1;
        if (r > 80) return 80;
        return r;
    endfunction

    // expected level after the k-th edge (k >= 1) for a lane with offset p
    function automatic bit exp_level(int k, int n, int p);
        int t;
        t = k - 1 - p;
        if (t < 0) return 1'b0;
        return (t % n) < ((n + 1) / 2);
    endfunction

    task automatic chk(string req, string what, bit act, bit exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic run_case(int r_in, int p_in, bit disturb);
        int n, p, cycles;
        string tref, tadj;
        n = eff_ratio(r_in);
        p = p_in % n;
        @(negedge clk_in);
        rst_n     = 1'b0;
        div_ratio = 7'(r_in);
        phase_off = 7'(p_in);
        repeat (3) @(negedge clk_in);
        #2;
        chk("R1", "ref in reset", clk_ref, 1'b0);
        chk("R1", "adj in reset", clk_adj, 1'b0);
        @(negedge clk_in);
        rst_n = 1'b1;
        if (disturb) begin
            div_ratio = 7'($urandom_range(0, 127));
            phase_off = 7'($urandom_range(0, 127));
        end
        tref = disturb ? "R2" : ((r_in == 0 || r_in > 80) ? "R7" : "R3");
        cycles = p + 2 * n + 2;
        for (int k = 1; k <= cycles; k++) begin
            @(posedge clk_in);
            #2;
            if (n == 1) begin
                chk("R8", "ref high phase", clk_ref, 1'b1);
                chk("R8", "adj high phase", clk_adj, 1'b1);
                #5;
                chk("R8", "ref low phase", clk_ref, 1'b0);
                chk("R8", "adj low phase", clk_adj, 1'b0);
            end else begin
                if (disturb) tadj = "R2";
                else if (p_in >= n || p == 0) tadj = "R6";
                else if (k <= p + 1) tadj = "R4";
                else tadj = "R5";
                chk(tref, $sformatf("ref n=%0d k=%0d", n, k), clk_ref, exp_level(k, n, 0));
                chk(tadj, $sformatf("adj n=%0d p=%0d k=%0d", n, p, k), clk_adj, exp_level(k, n, p));
            end
        end
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5EED_0042);
        repeat (2) @(negedge clk_in);
        // directed corners
        run_case(16, 4, 1'b0);   // quarter-period shift
        run_case(32, 1, 1'b0);
        run_case(2, 1, 1'b0);
        run_case(3, 2, 1'b0);
        run_case(7, 0, 1'b0);    // R6 zero offset
        run_case(5, 12, 1'b0);   // R6 wrap
        run_case(80, 79, 1'b0);
        run_case(0, 3, 1'b0);    // R7 clamp low -> bypass
        run_case(127, 85, 1'b0); // R7 clamp high
        run_case(1, 0, 1'b0);    // R8
        run_case(9, 4, 1'b1);    // R2 disturbance
        // random mix
        for (int i = 0; i < 30; i++) begin
            run_case($urandom_range(0, 100), $urandom_range(0, 127), ($urandom_range(0, 3) == 0));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk_in);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule